// File: doc/BRIEF.md
# Hashed Two-Half Target Comparator

This block sits at the output of a key-search pipeline. Each cycle the pipeline can offer one 64-bit ciphertext together with the key that produced it. The block folds the ciphertext into a table index and looks it up in a table of targets. The table lives in an external synchronous memory that is 32 bits wide, so each target occupies two consecutive words. One lookup checks a candidate against every stored target at once, because a candidate can only equal the target held in its own slot.

The upper half of the target is compared first. Most candidates fail that test, and the pipeline keeps running at one candidate per cycle. When the upper half agrees, the block raises a stall for a single cycle. During that cycle it reads the lower word. If the lower word also agrees, the key is reported and held until the host acknowledges it.

The host fills the table through a load port while no search traffic is present. A target whose slot is already taken is refused, and the earlier target stays in place. The slot count is set by the index width. The default index width is reduced from the full 14 bits so that the per-slot valid flags stay small.

Top module: `hashed_match_cmp`

## Requirements
- R1: The slot index bit i is the XOR of every ciphertext bit j for which j mod IDX_W equals i. A target with slot s keeps bits 63:32 at word address 2s and bits 31:0 at word address 2s+1.
- R2: A load request made while idle, whose slot is empty, does three things. It writes the upper word in the request cycle and the lower word in the next cycle. It then pulses load_done with load_ok=1 in the cycle after the lower-word write. From then on the slot is valid.
- R3: A load request made while idle, whose slot is already valid, writes no memory. It pulses load_done with load_ok=0 in the next cycle, and the stored target keeps matching.
- R4: A load request is ignored, with no write and no load_done, when any of these holds: cand_valid is high, a candidate is still being compared, or a load is in its second cycle.
- R5: A candidate is accepted in any cycle where cand_valid is high and stall is low. The read of its upper word at address 2s is issued in that same cycle.
- R6: If an accepted candidate's slot is valid and its upper word matches, stall is high in the next cycle for exactly one cycle, and the lower-word read is issued in that cycle. Stall is also high during the second cycle of a load. A candidate offered while stall is high is not accepted and must be held.
- R7: When both halves match, found rises two cycles after the stall cycle, and found_key equals the key that came with that ciphertext.
- R8: found and found_key hold while found is high and found_ack is low. A full match that completes in a cycle where found_ack is high, or where found is low, replaces the held key. A match that completes while a key is held and not acknowledged is dropped.
- R9: A candidate whose slot is not valid never raises stall or found, whatever the memory holds.
- R10: Reset clears every slot valid flag, stall, found, load_done and any candidate in flight.
- R11: If the upper half matches but the lower half differs, there is a one-cycle stall and found stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid | input | 1 | A candidate is offered |
| cand_ct | input | 64 | Candidate ciphertext |
| cand_key | input | KEY_W | Key that produced the candidate |
| stall | output | 1 | Candidate not accepted this cycle |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | IDX_W+1 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |
| load_req | input | 1 | Host target load request (one cycle) |
| load_target | input | 64 | Target to store |
| load_done | output | 1 | Load finished (one-cycle pulse) |
| load_ok | output | 1 | Target stored (1) or refused as a collision (0) |
| found | output | 1 | A full match is held |
| found_key | output | KEY_W | Key of the held match |
| found_ack | input | 1 | Host releases the held match |

## Verification
The assertions check several rules on every cycle. A first-half stall never lasts more than one cycle, and no upper-word read is issued while stall is high. Memory is written only when no candidate is being compared. A held match stays constant until it is acknowledged, and a candidate whose slot is empty never causes a stall. Other behaviour can only be shown by the bench's scenarios: loads that are refused or ignored leave the table unchanged, and the key reported for a full match is the right one. Further scenarios show a held key surviving a later match and being replaced under acknowledgement, an upper-half-only hit, and a slot that is empty but whose memory words agree with the candidate.

// File: rtl/hmc_pkg.sv
package hmc_pkg;
    localparam int CT_W   = 64;
    localparam int HALF_W = CT_W / 2;

    typedef logic [CT_W-1:0]   ct_t;
    typedef logic [HALF_W-1:0] half_t;

    function automatic half_t upper_half(input ct_t w);
        return w[CT_W-1:HALF_W];
    endfunction

    function automatic half_t lower_half(input ct_t w);
        return w[HALF_W-1:0];
    endfunction
endpackage

// File: rtl/hmc_hash_fold.sv
module hmc_hash_fold
    import hmc_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  ct_t              word_i,
    output logic [IDX_W-1:0] idx_o
);
    // R1: index bit b folds every word bit whose position is b modulo IDX_W
    for (genvar b = 0; b < IDX_W; b++) begin : g_bit
        logic fold_bit;
        always_comb begin
            fold_bit = 1'b0;
            for (int j = b; j < CT_W; j += IDX_W) begin
                fold_bit = fold_bit ^ word_i[j];
            end
        end
        assign idx_o[b] = fold_bit;
    end
endmodule

// File: rtl/hmc_slot_flags.sv
module hmc_slot_flags #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_flag
);
    localparam int SLOTS = 1 << IDX_W;

    logic [SLOTS-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (set_en) begin
            flags_d[set_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign rd_flag = flags_q[rd_idx];
endmodule

// File: rtl/hashed_match_cmp.sv
module hashed_match_cmp
    import hmc_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int KEY_W = 56
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cand_valid,
    input  logic [63:0]        cand_ct,
    input  logic [KEY_W-1:0]   cand_key,
    output logic               stall,
    output logic               mem_en,
    output logic               mem_we,
    output logic [IDX_W:0]     mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata,
    input  logic               load_req,
    input  logic [63:0]        load_target,
    output logic               load_done,
    output logic               load_ok,
    output logic               found,
    output logic [KEY_W-1:0]   found_key,
    input  logic               found_ack
);
    typedef struct packed {
        logic               s1_v;
        logic               s1_slot;
        ct_t                s1_ct;
        logic [KEY_W-1:0]   s1_key;
        logic [IDX_W-1:0]   s1_idx;
        logic               s2_v;
        half_t              s2_lo;
        logic [KEY_W-1:0]   s2_key;
        logic               wr2;
        half_t              wr_lo;
        logic [IDX_W-1:0]   wr_idx;
        logic               done;
        logic               ok;
        logic               fnd;
        logic [KEY_W-1:0]   fkey;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0] cand_idx, load_idx, flag_rd_idx;
    logic             slot_flag;
    logic             hit_upper, hit_lower, accept, idle, load_go, collide;

    hmc_hash_fold #(.IDX_W(IDX_W)) u_hash_cand (
        .word_i (cand_ct),
        .idx_o  (cand_idx)
    );

    hmc_hash_fold #(.IDX_W(IDX_W)) u_hash_load (
        .word_i (load_target),
        .idx_o  (load_idx)
    );

    assign flag_rd_idx = cand_valid ? cand_idx : load_idx;

    hmc_slot_flags #(.IDX_W(IDX_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (st_q.wr2),
        .set_idx (st_q.wr_idx),
        .rd_idx  (flag_rd_idx),
        .rd_flag (slot_flag)
    );

    always_comb begin
        hit_upper = st_q.s1_v && st_q.s1_slot && (mem_rdata == upper_half(st_q.s1_ct));
        hit_lower = st_q.s2_v && (mem_rdata == st_q.s2_lo);
        stall     = hit_upper || st_q.wr2;
        accept    = cand_valid && !stall;
        idle      = !cand_valid && !st_q.s1_v && !st_q.s2_v && !st_q.wr2;
        load_go   = load_req && idle;
        collide   = slot_flag;

        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (st_q.wr2) begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {st_q.wr_idx, 1'b1};
            mem_wdata = st_q.wr_lo;
        end else if (hit_upper) begin
            mem_en    = 1'b1;
            mem_addr  = {st_q.s1_idx, 1'b1};
        end else if (accept) begin
            mem_en    = 1'b1;
            mem_addr  = {cand_idx, 1'b0};
        end else if (load_go && !collide) begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {load_idx, 1'b0};
            mem_wdata = upper_half(load_target);
        end

        st_d = st_q;
        // second compare stage takes over a first-half hit
        st_d.s2_v   = hit_upper;
        st_d.s2_lo  = lower_half(st_q.s1_ct);
        st_d.s2_key = st_q.s1_key;
        // first compare stage
        st_d.s1_v = accept;
        if (accept) begin
            st_d.s1_slot = slot_flag;
            st_d.s1_ct   = cand_ct;
            st_d.s1_key  = cand_key;
            st_d.s1_idx  = cand_idx;
        end
        // table loading
        st_d.wr2  = load_go && !collide;
        st_d.done = st_q.wr2 || (load_go && collide);
        st_d.ok   = st_q.wr2;
        if (load_go) begin
            st_d.wr_lo  = lower_half(load_target);
            st_d.wr_idx = load_idx;
        end
        // result holding
        if (st_q.fnd && !found_ack) begin
            st_d.fnd = 1'b1;
        end else if (hit_lower) begin
            st_d.fnd  = 1'b1;
            st_d.fkey = st_q.s2_key;
        end else begin
            st_d.fnd = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_done = st_q.done;
    assign load_ok   = st_q.ok;
    assign found     = st_q.fnd;
    assign found_key = st_q.fkey;

    // R6: a stall caused by a first-half hit lasts one cycle only
    a_r6_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
        hit_upper |=> !hit_upper);

    // R6: no new upper-word read while the pipeline is held
    a_r6_no_read_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !(mem_en && !mem_we && !mem_addr[0]));

    // R4: table writes never overlap an in-flight comparison
    a_r4_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!st_q.s1_v && !st_q.s2_v));

    // R8: a held match is stable until acknowledged
    a_r8_found_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !found_ack) |=> (found && $stable(found_key)));

    // R9: an empty slot never stalls the pipeline
    a_r9_empty_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_v && !st_q.s1_slot) |-> !stall);
endmodule

// File: tb/hashed_match_cmp_tb_top.sv
module hashed_match_cmp_tb_top;
    localparam int IW = 10;
    localparam int KW = 56;
    localparam int WORDS = 1 << (IW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          cand_valid = 1'b0;
    logic [63:0]   cand_ct = '0;
    logic [KW-1:0] cand_key = '0;
    logic          stall;
    logic          mem_en, mem_we;
    logic [IW:0]   mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          load_req = 1'b0;
    logic [63:0]   load_target = '0;
    logic          load_done, load_ok, found;
    logic [KW-1:0] found_key;
    logic          found_ack = 1'b0;

    hashed_match_cmp #(.IDX_W(IW), .KEY_W(KW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_ct(cand_ct),
        .cand_key(cand_key), .stall(stall), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .load_req(load_req), .load_target(load_target), .load_done(load_done),
        .load_ok(load_ok), .found(found), .found_key(found_key), .found_ack(found_ack)
    );

    // external table memory, one-cycle read
    logic [31:0] mem [0:WORDS-1];
    logic        poke_en = 1'b0;
    logic [IW:0] poke_addr = '0;
    logic [31:0] poke_data = '0;
    always @(posedge clk) begin
        if (poke_en) mem[poke_addr] <= poke_data;
        else if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else mem_rdata <= mem[mem_addr];
        end
    end

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit good, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [IW-1:0] slot_of(input logic [63:0] w);
        logic [IW-1:0] r = '0;
        for (int i = 0; i < IW; i++) begin
            for (int j = i; j < 64; j += IW) r[i] = r[i] ^ w[j];
        end
        return r;
    endfunction

    // behavioural reference
    logic [63:0]   tbl [int];
    bit            m1_v = 0, m1_h1 = 0, m1_full = 0;
    logic [KW-1:0] m1_key = '0;
    bit            m2_v = 0, m2_full = 0;
    logic [KW-1:0] m2_key = '0;
    bit            m_wr2 = 0;
    int            m_wi = 0;
    logic [63:0]   m_wt = '0;
    bit            m_done = 0, m_ok = 0, m_fnd = 0;
    logic [KW-1:0] m_fkey = '0;

    task automatic compare_outputs();
        bit es;
        es = (m1_v && m1_h1) || m_wr2;
        chk(stall == es, "R6", "stall", 64'(stall), 64'(es));
        chk(found == m_fnd, "R7", "found", 64'(found), 64'(m_fnd));
        if (m_fnd) chk(found_key == m_fkey, "R8", "found_key", 64'(found_key), 64'(m_fkey));
        chk(load_done == m_done, "R2", "load_done", 64'(load_done), 64'(m_done));
        if (m_done) chk(load_ok == m_ok, "R3", "load_ok", 64'(load_ok), 64'(m_ok));
    endtask

    task automatic cyc(input bit cv, input logic [63:0] ct, input logic [KW-1:0] k,
                       input bit lr, input logic [63:0] lt, input bit ack, output bit acc);
        bit st, idle;
        int si;
        @(negedge clk);
        compare_outputs();
        st   = (m1_v && m1_h1) || m_wr2;
        idle = !cv && !m1_v && !m2_v && !m_wr2;
        if (!(m_fnd && !ack)) begin
            if (m2_v && m2_full) begin m_fnd = 1; m_fkey = m2_key; end
            else m_fnd = 0;
        end
        m2_v = m1_v && m1_h1; m2_full = m1_full; m2_key = m1_key;
        acc = cv && !st;
        m1_v = acc;
        if (acc) begin
            si = int'(slot_of(ct));
            m1_h1   = tbl.exists(si) && (tbl[si][63:32] == ct[63:32]);
            m1_full = tbl.exists(si) && (tbl[si] == ct);
            m1_key  = k;
        end
        m_done = 0; m_ok = 0;
        if (m_wr2) begin
            tbl[m_wi] = m_wt; m_done = 1; m_ok = 1; m_wr2 = 0;
        end else if (lr && idle) begin
            si = int'(slot_of(lt));
            if (tbl.exists(si)) m_done = 1;
            else begin m_wr2 = 1; m_wi = si; m_wt = lt; end
        end
        cand_valid = cv; cand_ct = ct; cand_key = k;
        load_req = lr; load_target = lt; found_ack = ack;
    endtask

    task automatic idle_n(input int n);
        bit a;
        for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, '0, 0, a);
    endtask

    task automatic send(input logic [63:0] ct, input logic [KW-1:0] k, input bit ack);
        bit a;
        do cyc(1, ct, k, 0, '0, ack, a); while (!a);
    endtask

    task automatic load(input logic [63:0] t);
        bit a;
        cyc(0, '0, '0, 1, t, 0, a);
    endtask

    task automatic poke(input int addr, input logic [31:0] d);
        poke_en = 1; poke_addr = (IW+1)'(addr); poke_data = d;
        idle_n(1);
        poke_en = 0;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL R10 watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] ta, tb, tc, td, te, tf;
        int ia, ib, ie, idxf;
        bit a;
        ta = 64'h0123_4567_89AB_CDEF;
        tb = 64'hFEDC_BA98_7654_3210;
        tc = ta ^ (64'h1 | (64'h1 << IW));   // same slot, lower half differs
        td = tc;                              // upper hit, lower miss
        ia = int'(slot_of(ta));
        ib = int'(slot_of(tb));
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            poke_en = 1; poke_addr = (IW+1)'(i); poke_data = '0;
        end
        @(negedge clk);
        poke_en = 0;
        repeat (2) @(negedge clk);
        // R10 reset state
        chk(stall == 0, "R10", "stall in reset", 64'(stall), 64'd0);
        chk(found == 0, "R10", "found in reset", 64'(found), 64'd0);
        chk(load_done == 0, "R10", "load_done in reset", 64'(load_done), 64'd0);
        rst_n = 1;
        idle_n(2);

        // R1 R2 loads
        load(ta); idle_n(3);
        chk(mem[2*ia] == ta[63:32], "R1", "upper word placement", 64'(mem[2*ia]), 64'(ta[63:32]));
        chk(mem[2*ia+1] == ta[31:0], "R1", "lower word placement", 64'(mem[2*ia+1]), 64'(ta[31:0]));
        if (ib == ia) tb = tb ^ 64'h2;
        ib = int'(slot_of(tb));
        load(tb); idle_n(3);
        chk(mem[2*ib] == tb[63:32], "R2", "second target stored", 64'(mem[2*ib]), 64'(tb[63:32]));
        // R3 collision refused
        load(tc); idle_n(3);
        chk(mem[2*ia+1] == ta[31:0], "R3", "collision left table", 64'(mem[2*ia+1]), 64'(ta[31:0]));

        // R4 load while a candidate is offered is ignored
        tf = 64'h5555_0000_AAAA_1111;
        idxf = int'(slot_of(tf));
        cyc(1, 64'h1111_2222_3333_4444, 56'h1, 1, tf, 0, a);
        idle_n(4);
        chk(mem[2*idxf] == ((idxf == ia) ? ta[63:32] : (idxf == ib) ? tb[63:32] : 32'h0),
            "R4", "ignored load wrote nothing", 64'(mem[2*idxf]), 64'd0);

        // R5 R7 stream with a full match
        for (int i = 0; i < 5; i++) send({$urandom, $urandom}, KW'(i), 0);
        send(ta, 56'hA1A1_A1A1_A1A1_A1, 0);
        for (int i = 0; i < 6; i++) send({$urandom, $urandom}, KW'(i), 0);
        chk(found == 1, "R7", "found after full match", 64'(found), 64'd1);
        chk(found_key == 56'hA1A1_A1A1_A1A1_A1, "R7", "reported key", 64'(found_key), 64'hA1A1_A1A1_A1A1_A1);

        // R8 later match while held is dropped
        send(tb, 56'hB2B2_B2B2_B2B2_B2, 0); idle_n(4);
        chk(found_key == 56'hA1A1_A1A1_A1A1_A1, "R8", "held key kept", 64'(found_key), 64'hA1A1_A1A1_A1A1_A1);
        cyc(0, '0, '0, 0, '0, 1, a); idle_n(2);
        chk(found == 0, "R8", "ack releases", 64'(found), 64'd0);

        // R11 upper hit, lower miss
        send(td, 56'hD, 0); idle_n(4);
        chk(found == 0, "R11", "no found on half match", 64'(found), 64'd0);

        // R6 back-to-back hits with ack held: later match replaces
        send(ta, 56'h33, 1);
        send(tb, 56'h44, 1);
        send(td, 56'h55, 1);
        send(ta, 56'h66, 1);
        idle_n(1);
        cyc(0, '0, '0, 0, '0, 1, a);
        idle_n(4);
        chk(found == 1, "R8", "replacement under ack", 64'(found), 64'd1);
        chk(found_key == 56'h66, "R8", "replaced key", 64'(found_key), 64'h66);
        cyc(0, '0, '0, 0, '0, 1, a); idle_n(2);

        // R9 empty slot whose memory holds the candidate
        te = ta;
        for (int k = 0; k < 64; k++) begin
            ie = int'(slot_of(te));
            if (!tbl.exists(ie)) break;
            te = te ^ (64'h1 << k);
        end
        ie = int'(slot_of(te));
        poke(2*ie, te[63:32]);
        poke(2*ie+1, te[31:0]);
        send(te, 56'hEE, 0); idle_n(4);
        chk(found == 0, "R9", "empty slot no found", 64'(found), 64'd0);

        idle_n(5);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule